// File: doc/BRIEF.md
# Tape record framer

The framer turns a byte stream into variable-length tape records held in a byte-wide synchronous memory, and walks those records again. Each record on the medium has a 32-bit length word, then the payload, then one zero filler byte when the length is odd, then a second copy of the length word. A record of length zero is a file mark. Since the length appears at both ends, the tape can be crossed in either direction.

A host issues one command at a time while `busy_o` is low. For a record write, it then streams the payload bytes. For a forward read, it receives the payload on the output byte port. Each command ends with a one-cycle `done_o`. The status flags (file mark, end of medium, bad record) stay valid until the next command starts. `bot_o` is a level that shows the position is zero. Writing always moves the end-of-data point to the new position, so a write truncates anything recorded beyond it.

Top module: `tape_framer`

## Requirements
- R1: After reset the position is 0, `bot_o` is 1, and `busy_o`, `done_o`, `out_valid_o` and all three status flags are 0.
- R2: Write record (op 0) stores the length as a little-endian 32-bit word at the start position. The payload bytes follow in order from start+4, then the trailer copy of the length word. The position advances by length + pad + 8.
- R3: When the length is odd, one byte of value 0 is stored directly after the payload. It is not counted in the length. When the length is even, no filler byte is stored.
- R4: If `in_abort_i` is high with the last byte, bit 31 of both length words is set. A later forward read or forward space over that record raises `st_bad_o`.
- R5: Write mark (op 1) stores four zero bytes at the position, advances it by 4 and raises `st_mark_o`.
- R6: Read forward (op 2) outputs every payload byte in stored order on `out_data_o`, with `out_last_o` on the final byte only. The last byte is output in the same cycle as `done_o`, and the position moves to the next record.
- R7: A forward read or forward space over a file mark raises `st_mark_o`, outputs no byte and advances the position by 4.
- R8: A forward read or forward space with the position at or past the end of written data raises `st_eom_o` and `st_mark_o` and leaves the position unchanged.
- R9: Space forward (op 3) moves the position past one record without asserting `out_valid_o`.
- R10: Space reverse (op 4) reads the trailer word below the position. Over a file mark it backs up 4 bytes and raises `st_mark_o`. Over a record it backs up to that record's start. It raises `st_bad_o` when the header word differs from the trailer word or carries bit 31.
- R11: Space reverse at position 0 completes in the next cycle without moving. `bot_o` stays 1 and no status flag is raised.
- R12: Rewind (op 5) sets the position to 0, and `done_o` is high in the cycle after the command.
- R13: After any write, the end of data equals the new position, so a forward read from there reports end of medium.
- R14: Op codes 6 and 7 are ignored: `busy_o` and `done_o` stay low and the position is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken only when not busy |
| cmd_op_i | input | 3 | Command code: 0 write record, 1 write mark, 2 read forward, 3 space forward, 4 space reverse, 5 rewind |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| st_mark_o | output | 1 | File mark seen or written |
| st_eom_o | output | 1 | End of written data reached |
| st_bad_o | output | 1 | Record flagged in error or inconsistent |
| bot_o | output | 1 | Position is zero |
| pos_o | output | ADDR_W | Current tape position in bytes |
| in_valid_i | input | 1 | Write payload byte valid |
| in_data_i | input | 8 | Write payload byte |
| in_last_i | input | 1 | Final payload byte |
| in_abort_i | input | 1 | Mark the record as bad, sampled with the last byte |
| out_valid_o | output | 1 | Read payload byte valid |
| out_data_o | output | 8 | Read payload byte |
| out_last_o | output | 1 | Final read payload byte |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, one cycle after the address |

## Verification
The assertions assume that the host sends commands only while `busy_o` is low. They also assume that every length word reached by a forward read or forward space describes a record lying inside the written data, so the position never passes the end of data. The bench drives commands only from the idle state. It walks forward only over records the framer wrote itself. Its single deliberate corruption touches header bits above the length field, which forward spacing ignores and only the reverse header check sees. All records are small enough that the written image stays well inside the memory.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  typedef enum logic [2:0] {
    OP_WREC  = 3'd0,
    OP_WMARK = 3'd1,
    OP_RDF   = 3'd2,
    OP_SPF   = 3'd3,
    OP_SPR   = 3'd4,
    OP_REW   = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WDATA,
    ST_WPAD,
    ST_WTRL,
    ST_WHDR,
    ST_WMARK,
    ST_RHDR,
    ST_EVAL,
    ST_RDATA,
    ST_DONE
  } state_e;
endpackage

// File: rtl/tpf_span.sv
module tpf_span #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] len_i,
  output logic              pad_o,
  output logic [ADDR_W:0]   span_o
);
  localparam int CW = ADDR_W + 1;

  assign pad_o  = len_i[0];
  // header + payload + filler + trailer
  assign span_o = {1'b0, len_i} + {{ADDR_W{1'b0}}, len_i[0]} + CW'(8);
endmodule

// File: rtl/tpf_word_cap.sv
module tpf_word_cap (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_en_i,
  input  logic [1:0]  idx_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o
);
  logic       en_q;
  logic [1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      idx_q <= 2'd0;
      word_o <= 32'd0;
    end else begin
      en_q  <= rd_en_i;
      idx_q <= idx_i;
      if (en_q) word_o[{idx_q, 3'b000} +: 8] <= byte_i;
    end
  end
endmodule

// File: rtl/tape_framer.sv
module tape_framer
  import tpf_pkg::*;
#(
  parameter int ADDR_W = 10  // at most 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              st_mark_o,
  output logic              st_eom_o,
  output logic              st_bad_o,
  output logic              bot_o,
  output logic [ADDR_W-1:0] pos_o,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_last_i,
  input  logic              in_abort_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_last_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int CW = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);
  localparam int HI_W = 31 - ADDR_W;

  state_e            st_q;
  op_e               op_q;
  logic [ADDR_W-1:0] pos_q, eod_q, base_q, len_q;
  logic [CW-1:0]     cnt_q;
  logic              wr_err_q, rev2_q;
  logic              mark_q, eom_q, bad_q;
  logic [31:0]       trl_q;
  logic              ov_q, ol_q;

  logic [31:0]       rword, wword;
  logic [ADDR_W-1:0] rlen;
  logic [CW-1:0]     rspan, wspan;
  logic              rpad, wpad;
  logic              cap_en;
  logic              cmd_go;

  assign cmd_go = cmd_valid_i && (st_q == ST_IDLE);
  assign rlen   = rword[ADDR_W-1:0];
  assign wword  = {wr_err_q, {HI_W{1'b0}}, len_q};

  tpf_span #(.ADDR_W(ADDR_W)) u_rspan (.len_i(rlen),  .pad_o(rpad), .span_o(rspan));
  tpf_span #(.ADDR_W(ADDR_W)) u_wspan (.len_i(len_q), .pad_o(wpad), .span_o(wspan));

  assign cap_en = (st_q == ST_RHDR) && (cnt_q < CW'(4));

  tpf_word_cap u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(cap_en),
    .idx_i  (cnt_q[1:0]),
    .byte_i (mem_rdata_i),
    .word_o (rword)
  );

  // memory port
  assign mem_addr_o = base_q + cnt_q[ADDR_W-1:0];
  assign mem_re_o   = cap_en || (st_q == ST_RDATA);

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = 8'd0;
    unique case (st_q)
      ST_WDATA: begin
        mem_we_o    = in_valid_i;
        mem_wdata_o = in_data_i;
      end
      ST_WPAD, ST_WMARK: mem_we_o = 1'b1;
      ST_WTRL, ST_WHDR: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = wword[{cnt_q[1:0], 3'b000} +: 8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_WREC;
      pos_q    <= '0;
      eod_q    <= '0;
      base_q   <= '0;
      len_q    <= '0;
      cnt_q    <= '0;
      wr_err_q <= 1'b0;
      rev2_q   <= 1'b0;
      mark_q   <= 1'b0;
      eom_q    <= 1'b0;
      bad_q    <= 1'b0;
      trl_q    <= '0;
      ov_q     <= 1'b0;
      ol_q     <= 1'b0;
    end else begin
      ov_q <= (st_q == ST_RDATA);
      ol_q <= (st_q == ST_RDATA) && (cnt_q == {1'b0, rlen} - CW'(1));
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          cnt_q  <= '0;
          rev2_q <= 1'b0;
          unique case (cmd_op_i)
            OP_WREC, OP_WMARK, OP_RDF, OP_SPF, OP_SPR, OP_REW: begin
              op_q   <= op_e'(cmd_op_i);
              mark_q <= 1'b0;
              eom_q  <= 1'b0;
              bad_q  <= 1'b0;
            end
            default: ;
          endcase
          unique case (cmd_op_i)
            OP_WREC: begin
              base_q <= pos_q + FOUR;
              st_q   <= ST_WDATA;
            end
            OP_WMARK: begin
              base_q <= pos_q;
              st_q   <= ST_WMARK;
            end
            OP_RDF, OP_SPF: begin
              if (pos_q >= eod_q) begin
                eom_q  <= 1'b1;
                mark_q <= 1'b1;
                st_q   <= ST_DONE;
              end else begin
                base_q <= pos_q;
                st_q   <= ST_RHDR;
              end
            end
            OP_SPR: begin
              if (pos_q == '0) st_q <= ST_DONE;
              else begin
                base_q <= pos_q - FOUR;
                st_q   <= ST_RHDR;
              end
            end
            OP_REW: begin
              pos_q <= '0;
              st_q  <= ST_DONE;
            end
            default: ;
          endcase
        end
        ST_WDATA: if (in_valid_i) begin
          if (in_last_i) begin
            len_q    <= cnt_q[ADDR_W-1:0] + ADDR_W'(1);
            wr_err_q <= in_abort_i;
            if (!cnt_q[0]) begin  // odd length: filler next
              cnt_q <= cnt_q + CW'(1);
              st_q  <= ST_WPAD;
            end else begin
              base_q <= base_q + cnt_q[ADDR_W-1:0] + ADDR_W'(1);
              cnt_q  <= '0;
              st_q   <= ST_WTRL;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_WPAD: begin
          base_q <= base_q + cnt_q[ADDR_W-1:0] + ADDR_W'(1);
          cnt_q  <= '0;
          st_q   <= ST_WTRL;
        end
        ST_WTRL: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q[1:0] == 2'd3) begin
            base_q <= pos_q;  // back-patch header
            cnt_q  <= '0;
            st_q   <= ST_WHDR;
          end
        end
        ST_WHDR: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q[1:0] == 2'd3) begin
            pos_q <= pos_q + wspan[ADDR_W-1:0];
            eod_q <= pos_q + wspan[ADDR_W-1:0];
            st_q  <= ST_DONE;
          end
        end
        ST_WMARK: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q[1:0] == 2'd3) begin
            pos_q  <= pos_q + FOUR;
            eod_q  <= pos_q + FOUR;
            mark_q <= 1'b1;
            st_q   <= ST_DONE;
          end
        end
        ST_RHDR: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(4)) begin
            cnt_q <= '0;
            st_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (op_q == OP_SPR && !rev2_q) begin
            if (rword == 32'd0) begin
              mark_q <= 1'b1;
              pos_q  <= pos_q - FOUR;
              st_q   <= ST_DONE;
            end else if (rspan > {1'b0, pos_q}) begin
              bad_q <= 1'b1;
              st_q  <= ST_DONE;
            end else begin
              trl_q  <= rword;
              base_q <= pos_q - rspan[ADDR_W-1:0];
              rev2_q <= 1'b1;
              st_q   <= ST_RHDR;
            end
          end else if (op_q == OP_SPR) begin
            bad_q <= (rword != trl_q) || rword[31];
            pos_q <= base_q;
            st_q  <= ST_DONE;
          end else if (rlen == '0) begin
            mark_q <= 1'b1;
            pos_q  <= pos_q + FOUR;
            st_q   <= ST_DONE;
          end else begin
            bad_q <= rword[31];
            if (op_q == OP_SPF) begin
              pos_q <= pos_q + rspan[ADDR_W-1:0];
              st_q  <= ST_DONE;
            end else begin
              base_q <= pos_q + FOUR;
              cnt_q  <= '0;
              st_q   <= ST_RDATA;
            end
          end
        end
        ST_RDATA: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == {1'b0, rlen} - CW'(1)) begin
            pos_q <= pos_q + rspan[ADDR_W-1:0];
            st_q  <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign st_mark_o   = mark_q;
  assign st_eom_o    = eom_q;
  assign st_bad_o    = bad_q;
  assign bot_o       = (pos_q == '0);
  assign pos_o       = pos_q;
  assign out_valid_o = ov_q;
  assign out_last_o  = ol_q;
  assign out_data_o  = mem_rdata_i;

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6: payload only leaves during a forward read
  a_r6_out_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (busy_o && op_q == OP_RDF));

  // R8: walking past written data never moves the position
  a_r8_eom_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && (cmd_op_i == OP_RDF || cmd_op_i == OP_SPF) && pos_q >= eod_q)
    |=> (done_o && st_eom_o && $stable(pos_q)));

  // R11: reverse at start of tape stays put
  a_r11_rev_at_bot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && cmd_op_i == OP_SPR && bot_o) |=> (done_o && bot_o && !st_bad_o && !st_mark_o));

  // R12: rewind lands at zero in one cycle
  a_r12_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && cmd_op_i == OP_REW) |=> (done_o && pos_o == '0));

  // R13: position never passes end of data
  a_r13_pos_le_eod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= eod_q);

  // R14: unused codes start nothing
  a_r14_bad_op_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && cmd_op_i > 3'd5) |=> (!busy_o && $stable(pos_o)));
endmodule

// File: tb/tape_framer_test.sv
`timescale 1ns/1ps
module tape_framer_test;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int NREC = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic [2:0]    cmd_op_i = 3'd0;
  logic          busy_o, done_o, st_mark_o, st_eom_o, st_bad_o, bot_o;
  logic [AW-1:0] pos_o;
  logic          in_valid_i = 1'b0;
  logic [7:0]    in_data_i = 8'd0;
  logic          in_last_i = 1'b0;
  logic          in_abort_i = 1'b0;
  logic          out_valid_o, out_last_o;
  logic [7:0]    out_data_o;
  logic          mem_re_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic [7:0]    mem_rdata;

  logic [7:0]    mem [0:DEPTH-1];
  logic          poke_en = 1'b0;
  logic [AW-1:0] poke_addr = '0;
  logic [7:0]    poke_data = 8'd0;

  int checks = 0;
  int fails = 0;
  int rx_n;
  logic [7:0] rx_d [0:63];
  logic       rx_l [0:63];
  int start_pos [0:NREC];

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    else if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata <= mem[mem_addr_o];
  end

  tape_framer #(.ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .busy_o(busy_o), .done_o(done_o),
    .st_mark_o(st_mark_o), .st_eom_o(st_eom_o), .st_bad_o(st_bad_o),
    .bot_o(bot_o), .pos_o(pos_o),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .in_last_i(in_last_i), .in_abort_i(in_abort_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o),
    .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(int len, int i);
    return 8'((len * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic int span_of(int len);
    return len + (len & 1) + 8;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_op_i = op;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    rx_n = 0;
    cyc = 0;
    forever begin
      if (out_valid_o && rx_n < 64) begin
        rx_d[rx_n] = out_data_o;
        rx_l[rx_n] = out_last_o;
        rx_n++;
      end
      if (done_o) break;
      @(negedge clk_i);
      cyc++;
      if (cyc > 4000) begin
        chk("timeout", cyc, 0);
        break;
      end
    end
  endtask

  task automatic run(input logic [2:0] op, output int cyc);
    issue(op);
    wait_done(cyc);
  endtask

  task automatic write_rec(int len, bit ab);
    int cyc;
    issue(3'd0);
    for (int i = 0; i < len; i++) begin
      in_valid_i = 1'b1;
      in_data_i = pat(len, i);
      in_last_i = (i == len - 1);
      in_abort_i = ab && (i == len - 1);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
    in_last_i = 1'b0;
    in_abort_i = 1'b0;
    wait_done(cyc);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc, len, st, hdr, pad, mark_at, end_at;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 pos", int'(pos_o), 0);
    chk("R1 bot", int'(bot_o), 1);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 out_valid", int'(out_valid_o), 0);
    chk("R1 flags", int'({st_mark_o, st_eom_o, st_bad_o}), 0);

    // R2 R3 R4 write sweep
    start_pos[0] = 0;
    for (int k = 0; k < NREC; k++) begin
      len = k + 1;
      st = start_pos[k];
      pad = len & 1;
      write_rec(len, len == 5);
      start_pos[k + 1] = st + span_of(len);
      chk("R2 pos after write", int'(pos_o), start_pos[k + 1]);
      hdr = ((len == 5) ? 32'h8000_0000 : 0) | len;
      for (int b = 0; b < 4; b++) begin
        chk("R2 R4 header byte", int'(mem[st + b]), (hdr >> (8 * b)) & 255);
        chk("R2 R4 trailer byte", int'(mem[st + 4 + len + pad + b]), (hdr >> (8 * b)) & 255);
      end
      for (int i = 0; i < len; i++)
        chk("R2 payload", int'(mem[st + 4 + i]), int'(pat(len, i)));
      if (pad == 1) chk("R3 filler", int'(mem[st + 4 + len]), 0);
    end

    // R5 mark
    mark_at = start_pos[NREC];
    run(3'd1, cyc);
    end_at = mark_at + 4;
    chk("R5 pos", int'(pos_o), end_at);
    chk("R5 mark flag", int'(st_mark_o), 1);
    for (int b = 0; b < 4; b++) chk("R5 mark byte", int'(mem[mark_at + b]), 0);

    // R12 rewind
    run(3'd5, cyc);
    chk("R12 latency", cyc, 0);
    chk("R12 pos", int'(pos_o), 0);
    chk("R12 bot", int'(bot_o), 1);

    // R6 R4 read forward
    for (int k = 0; k < NREC; k++) begin
      len = k + 1;
      run(3'd2, cyc);
      chk("R6 byte count", rx_n, len);
      for (int i = 0; i < rx_n; i++) begin
        chk("R6 data", int'(rx_d[i]), int'(pat(len, i)));
        chk("R6 last", int'(rx_l[i]), int'(i == len - 1));
      end
      chk("R4 bad on read", int'(st_bad_o), int'(len == 5));
      chk("R6 mark clear", int'(st_mark_o), 0);
      chk("R6 pos", int'(pos_o), start_pos[k + 1]);
    end
    run(3'd2, cyc);
    chk("R7 read mark flag", int'(st_mark_o), 1);
    chk("R7 read mark no data", rx_n, 0);
    chk("R7 read mark pos", int'(pos_o), end_at);
    run(3'd2, cyc);
    chk("R8 read eom", int'(st_eom_o), 1);
    chk("R8 read eom mark", int'(st_mark_o), 1);
    chk("R8 read eom pos", int'(pos_o), end_at);
    run(3'd3, cyc);
    chk("R8 space eom", int'(st_eom_o), 1);
    chk("R8 space eom pos", int'(pos_o), end_at);

    // R9 space forward
    run(3'd5, cyc);
    for (int k = 0; k < NREC; k++) begin
      run(3'd3, cyc);
      chk("R9 pos", int'(pos_o), start_pos[k + 1]);
      chk("R9 no output", rx_n, 0);
      chk("R4 bad on space", int'(st_bad_o), int'(k == 4));
    end
    run(3'd3, cyc);
    chk("R7 space mark flag", int'(st_mark_o), 1);
    chk("R7 space mark pos", int'(pos_o), end_at);

    // R10 space reverse
    run(3'd4, cyc);
    chk("R10 rev mark pos", int'(pos_o), mark_at);
    chk("R10 rev mark flag", int'(st_mark_o), 1);
    for (int k = NREC - 1; k >= 0; k--) begin
      run(3'd4, cyc);
      chk("R10 rev pos", int'(pos_o), start_pos[k]);
      chk("R10 rev bad", int'(st_bad_o), int'(k == 4));
      chk("R10 rev mark clear", int'(st_mark_o), 0);
    end

    // R11 reverse at start
    run(3'd4, cyc);
    chk("R11 latency", cyc, 0);
    chk("R11 pos", int'(pos_o), 0);
    chk("R11 bot", int'(bot_o), 1);
    chk("R11 flags", int'({st_mark_o, st_eom_o, st_bad_o}), 0);

    // R10 header mismatch
    @(negedge clk_i);
    poke_en = 1'b1;
    poke_addr = AW'(start_pos[3] + 3);
    poke_data = 8'h40;
    @(negedge clk_i);
    poke_en = 1'b0;
    run(3'd5, cyc);
    for (int k = 0; k < 4; k++) run(3'd3, cyc);
    chk("R10 fwd past patched", int'(pos_o), start_pos[4]);
    run(3'd4, cyc);
    chk("R10 mismatch bad", int'(st_bad_o), 1);
    chk("R10 mismatch pos", int'(pos_o), start_pos[3]);

    // R13 truncation
    run(3'd5, cyc);
    write_rec(3, 1'b0);
    chk("R13 pos", int'(pos_o), 12);
    run(3'd5, cyc);
    run(3'd3, cyc);
    chk("R13 space", int'(pos_o), 12);
    run(3'd2, cyc);
    chk("R13 eom", int'(st_eom_o), 1);
    chk("R13 no move", int'(pos_o), 12);

    // R14 unused codes
    for (int op = 6; op < 8; op++) begin
      issue(3'(op));
      chk("R14 not busy", int'(busy_o), 0);
      chk("R14 no done", int'(done_o), 0);
      repeat (3) @(negedge clk_i);
      chk("R14 pos", int'(pos_o), 12);
    end

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule